// File: doc/BRIEF.md
# Data TLB Miss Fault Classifier

This block sits behind the data translation lookaside buffer. When a data-side lookup misses, it receives a one-cycle miss strobe along with the access kind, the referenced address, the relevant processor status bits and the settings of the region the address falls in. It decides whether the miss becomes the alternate data TLB fault (walker disabled, collection active) or the nested data TLB fault (collection off). If neither applies, nothing is raised.

On an alternate fault it captures the faulting address. It also builds a default translation-information word from the region settings and assembles an interruption-status word. That status word applies masking rules that depend on the access kind and on legacy mode. On a nested fault only the vector offset changes, and the captured words keep their previous contents. Every result is registered and holds until the next fault. The fault-taken output pulses for one cycle per fault.

Top module: `dtlb_miss_classifier`

## Requirements
- R1: `acc_kind` encodes 0 load, 1 store, 2 semaphore, 3 non-access, 4 stack-engine mandatory fill, 5 stack-engine mandatory spill; codes 6 and 7 never fault. For kinds 0 to 3, a fault is raised only when `dtrans_en` is 1 and `rgn_walker_en` is 0.
- R2: For kinds 4 and 5, a fault is raised only when `rse_trans_en` is 1 and `rgn_walker_en` is 0; `dtrans_en` plays no part.
- R3: `collect_state` encodes 0 off, 1 on, 2 in-flight, 3 treated as off. Collection on or in-flight selects vector offset 0x1000 (alternate fault); otherwise the nested offset 0x1400 is selected.
- R4: `fault_taken` is high in the cycle after each clock edge that samples `miss_valid` with the fault conditions met, and low after any edge that does not. A strobe that raises no fault leaves every output unchanged.
- R5: On an alternate fault, `fault_addr` takes `data_addr`. A nested fault leaves `fault_addr`, `trans_info` and `intr_status` unchanged.
- R6: `trans_info` carries the region id at bits 8 upward and the page size at bits 7:2; every other bit is 0.
- R7: `intr_status[3:0]` holds `nonaccess_kind` for a non-access reference and 0 otherwise. Bit 35 (na) is 1 only for non-access references.
- R8: Bit 43 (ed) copies `defer_hint`, but is always 0 for stack-engine fill or spill.
- R9: Bit 39 (ni) is 0 when collection was on and 1 when it was in-flight.
- R10: When `legacy_mode` is 1, the code field (3:0), ed (43), ei (42:41), ir (38), rs (37), sp (36) and na (35) are all 0.
- R11: Bit 34 (r) is set for load, semaphore and fill. Bit 33 (w) is set for store, semaphore and spill. Bit 32 (x) is always 0.
- R12: Outside legacy mode, ei (42:41) copies `slot_idx`, rs (37) is 1 exactly for fill and spill, and sp (36) copies `spec_load` except for fill and spill, where it is 0. Bits so (40), ir (38), 31:4 and 63:44 are 0.
- R13: While reset is asserted, and after it, until the first fault, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | One-cycle data translation miss strobe |
| acc_kind | input | 3 | Access kind of the missing reference |
| legacy_mode | input | 1 | Reference comes from the legacy instruction set |
| data_addr | input | ADDR_W | Referenced data address |
| nonaccess_kind | input | 4 | Type of non-access operation |
| defer_hint | input | 1 | Exception deferral indication for the reference |
| slot_idx | input | 2 | Instruction slot of the faulting operation |
| spec_load | input | 1 | Reference is a speculative load |
| dtrans_en | input | 1 | Data address translation enabled |
| rse_trans_en | input | 1 | Stack-engine address translation enabled |
| collect_state | input | 2 | Interruption collection state |
| rgn_walker_en | input | 1 | Hardware walker enabled for the region |
| rgn_id | input | RID_W | Region identifier of the referenced region |
| rgn_page_size | input | PS_W | Preferred page size of the referenced region |
| vector_offset | output | VEC_W | Selected interruption vector offset |
| fault_taken | output | 1 | One-cycle fault indication |
| fault_addr | output | ADDR_W | Captured faulting address |
| trans_info | output | 64 | Default translation-information word |
| intr_status | output | 64 | Interruption-status word |

## Verification
Every result comes from a single register stage. After the clock edge that samples the strobe, the pulse, the vector and the three captured words are all valid together, and the pulse falls one edge later unless a new strobe arrives. The bench drives each stimulus on a falling edge. It checks all results on the next falling edge and checks the pulse and the held words again on the falling edge after that. This keeps every sample half a cycle away from the edge that changes the outputs. Back-to-back strobes, nested faults and a reset during operation are each checked at those same points.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  localparam logic [2:0] ACC_LOAD      = 3'd0;
  localparam logic [2:0] ACC_STORE     = 3'd1;
  localparam logic [2:0] ACC_SEMA      = 3'd2;
  localparam logic [2:0] ACC_NONACC    = 3'd3;
  localparam logic [2:0] ACC_STK_FILL  = 3'd4;
  localparam logic [2:0] ACC_STK_SPILL = 3'd5;

  localparam logic [1:0] COL_OFF      = 2'd0;
  localparam logic [1:0] COL_ON       = 2'd1;
  localparam logic [1:0] COL_INFLIGHT = 2'd2;

  // status word bit positions
  localparam int ST_X   = 32;
  localparam int ST_W   = 33;
  localparam int ST_R   = 34;
  localparam int ST_NA  = 35;
  localparam int ST_SP  = 36;
  localparam int ST_RS  = 37;
  localparam int ST_IR  = 38;
  localparam int ST_NI  = 39;
  localparam int ST_SO  = 40;
  localparam int ST_EI  = 41;
  localparam int ST_ED  = 43;

  // translation-info field positions
  localparam int TI_PS_LSB  = 2;
  localparam int TI_KEY_LSB = 8;

  localparam int WORD_W = 64;

endpackage

// File: rtl/dmc_rst_sync.sv
module dmc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/dmc_gate.sv
module dmc_gate
  import dmc_pkg::*;
#(
  parameter int                VEC_W      = 16,
  parameter logic [VEC_W-1:0]  ALT_VEC    = 16'h1000,
  parameter logic [VEC_W-1:0]  NESTED_VEC = 16'h1400
) (
  input  logic [2:0]       acc_kind,
  input  logic             dtrans_en,
  input  logic             rse_trans_en,
  input  logic             walker_en,
  input  logic [1:0]       collect_state,
  output logic             eligible,
  output logic             use_alt,
  output logic [VEC_W-1:0] vec
);
  logic is_data;
  logic is_stk;

  always_comb begin
    is_data  = (acc_kind == ACC_LOAD) || (acc_kind == ACC_STORE) ||
               (acc_kind == ACC_SEMA) || (acc_kind == ACC_NONACC);
    is_stk   = (acc_kind == ACC_STK_FILL) || (acc_kind == ACC_STK_SPILL);
    eligible = !walker_en && ((is_data && dtrans_en) || (is_stk && rse_trans_en));
    use_alt  = (collect_state == COL_ON) || (collect_state == COL_INFLIGHT);
    vec      = use_alt ? ALT_VEC : NESTED_VEC;
  end
endmodule

// File: rtl/dmc_info_build.sv
module dmc_info_build
  import dmc_pkg::*;
#(
  parameter int RID_W = 24,
  parameter int PS_W  = 6
) (
  input  logic [RID_W-1:0]  rgn_id,
  input  logic [PS_W-1:0]   rgn_page_size,
  output logic [WORD_W-1:0] info
);
  always_comb begin
    info = '0;
    info[TI_KEY_LSB +: RID_W] = rgn_id;
    info[TI_PS_LSB  +: PS_W]  = rgn_page_size;
  end
endmodule

// File: rtl/dmc_status_build.sv
module dmc_status_build
  import dmc_pkg::*;
(
  input  logic [2:0]        acc_kind,
  input  logic              legacy_mode,
  input  logic [3:0]        nonaccess_kind,
  input  logic              defer_hint,
  input  logic [1:0]        slot_idx,
  input  logic              spec_load,
  input  logic [1:0]        collect_state,
  output logic [WORD_W-1:0] status
);
  logic is_nonacc;
  logic is_stk;
  logic rd;
  logic wr;

  always_comb begin
    is_nonacc = (acc_kind == ACC_NONACC);
    is_stk    = (acc_kind == ACC_STK_FILL) || (acc_kind == ACC_STK_SPILL);
    rd        = (acc_kind == ACC_LOAD) || (acc_kind == ACC_SEMA) ||
                (acc_kind == ACC_STK_FILL);
    wr        = (acc_kind == ACC_STORE) || (acc_kind == ACC_SEMA) ||
                (acc_kind == ACC_STK_SPILL);

    status         = '0;
    status[ST_R]   = rd;
    status[ST_W]   = wr;
    status[ST_X]   = 1'b0;
    status[ST_NI]  = (collect_state == COL_INFLIGHT);
    status[ST_SO]  = 1'b0;
    status[ST_IR]  = 1'b0;
    if (!legacy_mode) begin
      status[3:0]            = is_nonacc ? nonaccess_kind : 4'd0;
      status[ST_NA]          = is_nonacc;
      status[ST_ED]          = is_stk ? 1'b0 : defer_hint;
      status[ST_EI +: 2]     = slot_idx;
      status[ST_RS]          = is_stk;
      status[ST_SP]          = is_stk ? 1'b0 : spec_load;
    end
  end
endmodule

// File: rtl/dtlb_miss_classifier.sv
module dtlb_miss_classifier
  import dmc_pkg::*;
#(
  parameter int               ADDR_W     = 64,
  parameter int               RID_W      = 24,
  parameter int               PS_W       = 6,
  parameter int               VEC_W      = 16,
  parameter logic [VEC_W-1:0] ALT_VEC    = 16'h1000,
  parameter logic [VEC_W-1:0] NESTED_VEC = 16'h1400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [2:0]        acc_kind,
  input  logic              legacy_mode,
  input  logic [ADDR_W-1:0] data_addr,
  input  logic [3:0]        nonaccess_kind,
  input  logic              defer_hint,
  input  logic [1:0]        slot_idx,
  input  logic              spec_load,
  input  logic              dtrans_en,
  input  logic              rse_trans_en,
  input  logic [1:0]        collect_state,
  input  logic              rgn_walker_en,
  input  logic [RID_W-1:0]  rgn_id,
  input  logic [PS_W-1:0]   rgn_page_size,
  output logic [VEC_W-1:0]  vector_offset,
  output logic              fault_taken,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [63:0]       trans_info,
  output logic [63:0]       intr_status
);
  logic              rst_n_sync;
  logic              eligible;
  logic              use_alt;
  logic [VEC_W-1:0]  vec_sel;
  logic [WORD_W-1:0] info_w;
  logic [WORD_W-1:0] status_w;

  logic              pulse_q,  pulse_d;
  logic [VEC_W-1:0]  vec_q,    vec_d;
  logic [ADDR_W-1:0] addr_q,   addr_d;
  logic [WORD_W-1:0] info_q,   info_d;
  logic [WORD_W-1:0] status_q, status_d;
  logic              cap_en;
  logic              alt_en;

  dmc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  dmc_gate #(
    .VEC_W      (VEC_W),
    .ALT_VEC    (ALT_VEC),
    .NESTED_VEC (NESTED_VEC)
  ) u_gate (
    .acc_kind      (acc_kind),
    .dtrans_en     (dtrans_en),
    .rse_trans_en  (rse_trans_en),
    .walker_en     (rgn_walker_en),
    .collect_state (collect_state),
    .eligible      (eligible),
    .use_alt       (use_alt),
    .vec           (vec_sel)
  );

  dmc_info_build #(
    .RID_W (RID_W),
    .PS_W  (PS_W)
  ) u_info (
    .rgn_id        (rgn_id),
    .rgn_page_size (rgn_page_size),
    .info          (info_w)
  );

  dmc_status_build u_status (
    .acc_kind       (acc_kind),
    .legacy_mode    (legacy_mode),
    .nonaccess_kind (nonaccess_kind),
    .defer_hint     (defer_hint),
    .slot_idx       (slot_idx),
    .spec_load      (spec_load),
    .collect_state  (collect_state),
    .status         (status_w)
  );

  // next state
  always_comb begin
    cap_en   = miss_valid && eligible;
    alt_en   = cap_en && use_alt;
    pulse_d  = cap_en;
    vec_d    = cap_en ? vec_sel  : vec_q;
    addr_d   = alt_en ? data_addr : addr_q;
    info_d   = alt_en ? info_w   : info_q;
    status_d = alt_en ? status_w : status_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      pulse_q  <= 1'b0;
      vec_q    <= '0;
      addr_q   <= '0;
      info_q   <= '0;
      status_q <= '0;
    end else begin
      pulse_q  <= pulse_d;
      vec_q    <= vec_d;
      addr_q   <= addr_d;
      info_q   <= info_d;
      status_q <= status_d;
    end
  end

  assign fault_taken   = pulse_q;
  assign vector_offset = vec_q;
  assign fault_addr    = addr_q;
  assign trans_info    = info_q;
  assign intr_status   = status_q;
endmodule

// File: rtl/dmc_chk.sv
module dmc_chk #(
  parameter int               ADDR_W  = 64,
  parameter int               VEC_W   = 16,
  parameter logic [VEC_W-1:0] ALT_VEC = 16'h1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_valid,
  input logic              legacy_mode,
  input logic [1:0]        collect_state,
  input logic              rgn_walker_en,
  input logic [VEC_W-1:0]  vector_offset,
  input logic              fault_taken,
  input logic [ADDR_W-1:0] fault_addr,
  input logic [63:0]       trans_info,
  input logic [63:0]       intr_status
);
  logic alt_now;
  assign alt_now = fault_taken && (vector_offset == ALT_VEC);

  // R4
  pulse_from_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_taken |-> $past(miss_valid));

  // R1
  walker_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(miss_valid && rgn_walker_en) |-> !fault_taken);

  // R6
  info_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alt_now |-> (trans_info[63:32] == 32'd0) && (trans_info[1:0] == 2'd0));

  // R11
  exec_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_taken |-> !intr_status[32]);

  // R9
  ni_follows_collect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alt_now |-> (intr_status[39] == ($past(collect_state) == 2'd2)));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alt_now |-> $stable(fault_addr));

  // R10
  legacy_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_now && $past(legacy_mode)) |->
      (intr_status[3:0] == 4'd0) && (intr_status[43:41] == 3'd0) &&
      (intr_status[38:35] == 4'd0));
endmodule

bind dtlb_miss_classifier dmc_chk #(
  .ADDR_W  (ADDR_W),
  .VEC_W   (VEC_W),
  .ALT_VEC (ALT_VEC)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .miss_valid    (miss_valid),
  .legacy_mode   (legacy_mode),
  .collect_state (collect_state),
  .rgn_walker_en (rgn_walker_en),
  .vector_offset (vector_offset),
  .fault_taken   (fault_taken),
  .fault_addr    (fault_addr),
  .trans_info    (trans_info),
  .intr_status   (intr_status)
);

// File: tb/dtlb_miss_classifier_tb.sv
module dtlb_miss_classifier_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 64;
  localparam int RID_W  = 24;
  localparam int PS_W   = 6;
  localparam logic [15:0] ALT_V    = 16'h1000;
  localparam logic [15:0] NESTED_V = 16'h1400;

  typedef struct packed {
    logic [2:0] acc;
    logic       leg;
    logic       dt;
    logic       rt;
    logic [1:0] col;
    logic       wk;
    logic [3:0] nat;
    logic       def;
    logic [1:0] slot;
    logic       spec;
    logic       exp_taken;
    logic       exp_alt;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0, 4'd0, 1'b1, 2'd1, 1'b1, 1'b1, 1'b1}, // R1 load
    '{3'd1, 1'b0, 1'b1, 1'b0, 2'd2, 1'b0, 4'd0, 1'b0, 2'd2, 1'b0, 1'b1, 1'b1}, // R9 store in-flight
    '{3'd2, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0, 4'd0, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1}, // R11 semaphore
    '{3'd3, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0, 4'd5, 1'b1, 2'd3, 1'b1, 1'b1, 1'b1}, // R7 non-access
    '{3'd4, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 4'd0, 1'b1, 2'd1, 1'b1, 1'b1, 1'b1}, // R2 R8 fill
    '{3'd5, 1'b0, 1'b1, 1'b1, 2'd2, 1'b0, 4'd9, 1'b1, 2'd2, 1'b0, 1'b1, 1'b1}, // R12 spill
    '{3'd0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 4'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0}, // R1 no dt
    '{3'd0, 1'b0, 1'b1, 1'b1, 2'd1, 1'b1, 4'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0}, // R1 walker on
    '{3'd4, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0, 4'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0}, // R2 no rt
    '{3'd3, 1'b1, 1'b1, 1'b0, 2'd1, 1'b0, 4'd7, 1'b1, 2'd3, 1'b1, 1'b1, 1'b1}, // R10 legacy
    '{3'd1, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 4'd0, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0}, // R3 nested
    '{3'd0, 1'b0, 1'b1, 1'b0, 2'd3, 1'b0, 4'd0, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0}, // R3 code 3
    '{3'd6, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0, 4'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0}, // R1 code 6
    '{3'd1, 1'b1, 1'b1, 1'b0, 2'd2, 1'b0, 4'd0, 1'b1, 2'd1, 1'b1, 1'b1, 1'b1}  // R10 legacy store
  };

  logic              clk;
  logic              rst_n;
  logic              miss_valid;
  logic [2:0]        acc_kind;
  logic              legacy_mode;
  logic [ADDR_W-1:0] data_addr;
  logic [3:0]        nonaccess_kind;
  logic              defer_hint;
  logic [1:0]        slot_idx;
  logic              spec_load;
  logic              dtrans_en;
  logic              rse_trans_en;
  logic [1:0]        collect_state;
  logic              rgn_walker_en;
  logic [RID_W-1:0]  rgn_id;
  logic [PS_W-1:0]   rgn_page_size;
  logic [15:0]       vector_offset;
  logic              fault_taken;
  logic [ADDR_W-1:0] fault_addr;
  logic [63:0]       trans_info;
  logic [63:0]       intr_status;

  int n_chk = 0;
  int n_err = 0;
  logic done = 1'b0;

  logic [15:0] e_vec  = '0;
  logic [63:0] e_addr = '0;
  logic [63:0] e_info = '0;
  logic [63:0] e_stat = '0;

  dtlb_miss_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .acc_kind(acc_kind),
    .legacy_mode(legacy_mode), .data_addr(data_addr), .nonaccess_kind(nonaccess_kind),
    .defer_hint(defer_hint), .slot_idx(slot_idx), .spec_load(spec_load),
    .dtrans_en(dtrans_en), .rse_trans_en(rse_trans_en), .collect_state(collect_state),
    .rgn_walker_en(rgn_walker_en), .rgn_id(rgn_id), .rgn_page_size(rgn_page_size),
    .vector_offset(vector_offset), .fault_taken(fault_taken), .fault_addr(fault_addr),
    .trans_info(trans_info), .intr_status(intr_status)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] model_status(input vec_t v);
    logic [63:0] s = '0;
    logic na  = (v.acc == 3'd3);
    logic stk = (v.acc == 3'd4) || (v.acc == 3'd5);
    s[34] = (v.acc == 3'd0) || (v.acc == 3'd2) || (v.acc == 3'd4);
    s[33] = (v.acc == 3'd1) || (v.acc == 3'd2) || (v.acc == 3'd5);
    s[39] = (v.col == 2'd2);
    if (!v.leg) begin
      if (na) s[3:0] = v.nat;
      s[35]    = na;
      s[43]    = stk ? 1'b0 : v.def;
      s[42:41] = v.slot;
      s[37]    = stk;
      s[36]    = stk ? 1'b0 : v.spec;
    end
    return s;
  endfunction

  task automatic drive(input vec_t v, input logic [63:0] a,
                       input logic [23:0] rid, input logic [5:0] ps);
    miss_valid     = 1'b1;
    acc_kind       = v.acc;
    legacy_mode    = v.leg;
    dtrans_en      = v.dt;
    rse_trans_en   = v.rt;
    collect_state  = v.col;
    rgn_walker_en  = v.wk;
    nonaccess_kind = v.nat;
    defer_hint     = v.def;
    slot_idx       = v.slot;
    spec_load      = v.spec;
    data_addr      = a;
    rgn_id         = rid;
    rgn_page_size  = ps;
  endtask

  task automatic update_model(input vec_t v, input logic [63:0] a,
                              input logic [23:0] rid, input logic [5:0] ps);
    if (v.exp_taken) begin
      e_vec = v.exp_alt ? ALT_V : NESTED_V;
      if (v.exp_alt) begin
        e_addr = a;
        e_info = {32'd0, rid, ps, 2'b00};
        e_stat = model_status(v);
      end
    end
  endtask

  task automatic check_held(input string req);
    chk(req, "vector", {48'd0, vector_offset}, {48'd0, e_vec});
    chk(req, "fault_addr", fault_addr, e_addr);
    chk(req, "trans_info", trans_info, e_info);
    chk(req, "intr_status", intr_status, e_stat);
  endtask

  initial begin
    miss_valid = 1'b0; acc_kind = '0; legacy_mode = 1'b0; data_addr = '0;
    nonaccess_kind = '0; defer_hint = 1'b0; slot_idx = '0; spec_load = 1'b0;
    dtrans_en = 1'b0; rse_trans_en = 1'b0; collect_state = '0;
    rgn_walker_en = 1'b0; rgn_id = '0; rgn_page_size = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R13 outputs during reset
    chk("R13", "pulse in reset", {63'd0, fault_taken}, 64'd0);
    check_held("R13");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R13", "pulse after reset", {63'd0, fault_taken}, 64'd0);
    check_held("R13");

    for (int i = 0; i < NV; i++) begin
      logic [63:0] a   = 64'h1234_5678_0000_0000 ^ (64'(i) * 64'h9E37_79B9);
      logic [23:0] rid = 24'hA0_0000 + 24'(i * 3);
      logic [5:0]  ps  = 6'd12 + 6'(i);
      drive(TBL[i], a, rid, ps);
      update_model(TBL[i], a, rid, ps);
      @(negedge clk);
      miss_valid = 1'b0;
      chk("R4", $sformatf("pulse row %0d", i), {63'd0, fault_taken},
          {63'd0, TBL[i].exp_taken});
      check_held($sformatf("R5 row %0d", i));
      @(negedge clk);
      chk("R4", $sformatf("pulse low row %0d", i), {63'd0, fault_taken}, 64'd0);
      check_held($sformatf("R4 hold row %0d", i));
    end

    // R4 back-to-back strobes: both faults pulse, second one captured
    begin
      vec_t v1 = TBL[0];
      vec_t v2 = TBL[1];
      drive(v1, 64'hAAAA_0000_0000_1111, 24'h00_0011, 6'd14);
      update_model(v1, 64'hAAAA_0000_0000_1111, 24'h00_0011, 6'd14);
      @(negedge clk);
      chk("R4", "back-to-back first", {63'd0, fault_taken}, 64'd1);
      check_held("R5");
      drive(v2, 64'hBBBB_0000_0000_2222, 24'h00_0022, 6'd16);
      update_model(v2, 64'hBBBB_0000_0000_2222, 24'h00_0022, 6'd16);
      @(negedge clk);
      miss_valid = 1'b0;
      chk("R4", "back-to-back second", {63'd0, fault_taken}, 64'd1);
      check_held("R5");
      @(negedge clk);
      chk("R4", "back-to-back tail", {63'd0, fault_taken}, 64'd0);
    end

    // R5 nested fault after alternate keeps captured words
    begin
      vec_t vn = TBL[10];
      drive(vn, 64'hDEAD_BEEF_0000_0000, 24'hFF_FFFF, 6'd63);
      update_model(vn, 64'hDEAD_BEEF_0000_0000, 24'hFF_FFFF, 6'd63);
      @(negedge clk);
      miss_valid = 1'b0;
      chk("R3", "nested vector", {48'd0, vector_offset}, {48'd0, NESTED_V});
      check_held("R5 nested");
    end

    // R13 reset during operation clears everything
    rst_n = 1'b0;
    @(negedge clk);
    e_vec = '0; e_addr = '0; e_info = '0; e_stat = '0;
    chk("R13", "pulse mid reset", {63'd0, fault_taken}, 64'd0);
    check_held("R13 mid");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule